// File: doc/BRIEF.md
# Asynchronous Pseudo-Static RAM Bus Controller

This block sits between a synchronous host and an asynchronous 16-bit pseudo-static RAM with an 18-bit word address. The host raises a request carrying an address, write data, a read/write flag and two active-high byte-lane selects. The request is held until the controller returns a one-cycle acknowledge, together with read data for reads. On the memory side the controller generates a pair of chip selects of opposite polarity, write and output strobes, active-low upper and lower byte strobes, and a data bus split into separate out, in and drive-enable signals.

All memory timing is expressed in nanosecond parameters and converted to clock-cycle counts with a clock-period parameter, rounding up. A read is a chip-select-controlled access: the address is set up one cycle ahead, then select, output enable and byte strobes assert together. Data is sampled at the edge where the access count ends. A write asserts write strobe, select, byte strobes and the data drivers together for the longest of the write-window minimums. After that comes a recovery phase that completes the minimum write cycle. After every read, a turnaround count keeps the data drivers off until the memory's outputs have had time to release.

Top module: `psram_host_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, mem_cs_n=1, mem_cs=0, mem_we_n=1, mem_oe_n=1, mem_ub_n=1, mem_lb_n=1, mem_dq_oe=0 and req_ack=0.
- R2: The address appears on mem_addr at least one cycle before the chip selects go active, and it does not change while they are active or in the cycle after they release.
- R3: A read keeps the selects and mem_oe_n active, with mem_we_n high, for C_RD = ceil(max(tRC, tAA, tACE)/period) cycles (6 at defaults). Data is captured at the last edge of that window, and req_ack follows in the next cycle. Lane 0 is bits 7:0 and lane 1 is bits 15:8, and a lane not selected reads back as zero.
- R4: A write holds mem_we_n low, the selects active and the selected byte strobes low for C_WA = ceil(max(tPWE, tAW, tSCE, tBW, tSD)/period) cycles (5 at defaults). The data drivers are on for that whole window, and all of these strobes end on the same edge.
- R5: After a write window, a recovery phase of max(1, C_WC - C_WA) cycles, with C_WC = ceil(tWC/period), keeps the data driven with the strobes released. req_ack follows that phase, so the latency from request to acknowledge is 2 + C_WA + recovery cycles.
- R6: req_lanes bit 0 drives mem_lb_n low and bit 1 drives mem_ub_n low. A write changes only the selected lanes of the stored word.
- R7: A request with req_lanes = 0 is acknowledged in the cycle after it is accepted. The chip selects are never asserted for it, and the stored word stays unchanged.
- R8: mem_dq_oe rises only after mem_oe_n has been high for at least C_HZ = ceil(tHZ/period) cycles (3 at defaults). A write that directly follows a read is delayed as needed.
- R9: mem_we_n and mem_oe_n are never low together, and mem_dq_oe is never high while mem_oe_n is low.
- R10: req_ack is high for exactly one cycle per request, and a request is accepted only while req_ack is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request, held until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_lanes | input | 2 | Active-high byte-lane selects (bit 1 upper) |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 18 | Memory address |
| mem_cs_n | output | 1 | Active-low chip select |
| mem_cs | output | 1 | Active-high chip select |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_ub_n | output | 1 | Active-low upper byte strobe |
| mem_lb_n | output | 1 | Active-low lower byte strobe |
| mem_dq_o | output | 16 | Data driven toward memory |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_o |
| mem_dq_i | input | 16 | Data from memory |

## Verification
The two functions that can fall in the same cycle are the release of the memory's read drivers and the start of a following write's own drivers. The bench provokes this by issuing a write in the cycle right after a read's acknowledge, with no idle cycle between them. A negative-edge monitor measures how many cycles mem_oe_n was high before mem_dq_oe rose, and the case passes only if that count is at least C_HZ and the written word reads back intact.

// File: rtl/psram_host_ctrl.sv
`timescale 1ns/1ps
module psram_host_ctrl #(
  parameter int CLK_NS   = 10,
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int T_RC_NS  = 55,
  parameter int T_AA_NS  = 55,
  parameter int T_ACE_NS = 55,
  parameter int T_WC_NS  = 55,
  parameter int T_PWE_NS = 40,
  parameter int T_AW_NS  = 45,
  parameter int T_SCE_NS = 45,
  parameter int T_BW_NS  = 50,
  parameter int T_SD_NS  = 25,
  parameter int T_HZ_NS  = 25
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [1:0]        req_lanes,
  output logic              req_ack,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_cs_n,
  output logic              mem_cs,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic              mem_ub_n,
  output logic              mem_lb_n,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int LANE  = DATA_W / 2;
  localparam int C_RD  = imax(ns2cyc(T_RC_NS), imax(ns2cyc(T_AA_NS), ns2cyc(T_ACE_NS)));
  localparam int C_WA  = imax(imax(ns2cyc(T_PWE_NS), ns2cyc(T_AW_NS)),
                              imax(ns2cyc(T_SCE_NS), imax(ns2cyc(T_BW_NS), ns2cyc(T_SD_NS))));
  localparam int C_WC  = ns2cyc(T_WC_NS);
  localparam int C_REC = (C_WC > C_WA) ? (C_WC - C_WA) : 1;
  localparam int C_HZ  = ns2cyc(T_HZ_NS);
  localparam int C_MAX = imax(C_RD, imax(C_WA, C_REC));
  localparam int CW    = $clog2(C_MAX + 1);
  localparam int HW    = $clog2(C_HZ + 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_RD, S_WR, S_REC} state_t;

  state_t            state;
  logic [CW-1:0]     cnt;
  logic [HW-1:0]     hz;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [1:0]        lanes_q;
  logic              wr_q;
  logic [DATA_W-1:0] rd_masked;

  wire active = (state == S_RD) || (state == S_WR);

  assign mem_addr  = addr_q;
  assign mem_dq_o  = wdata_q;
  assign mem_cs_n  = ~active;
  assign mem_cs    = active;
  assign mem_oe_n  = (state != S_RD);
  assign mem_we_n  = (state != S_WR);
  assign mem_lb_n  = ~(active & lanes_q[0]);
  assign mem_ub_n  = ~(active & lanes_q[1]);
  assign mem_dq_oe = (state == S_WR) || (state == S_REC);

  for (genvar g = 0; g < 2; g++) begin : g_lane
    assign rd_masked[g*LANE +: LANE] = lanes_q[g] ? mem_dq_i[g*LANE +: LANE] : '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      cnt       <= '0;
      hz        <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      lanes_q   <= '0;
      wr_q      <= 1'b0;
      req_ack   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      req_ack <= 1'b0;
      if (hz != '0) hz <= hz - 1'b1;
      case (state)
        S_IDLE: if (req_valid && !req_ack) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          lanes_q <= req_lanes;
          wr_q    <= req_write;
          if (req_lanes == 2'b00) req_ack <= 1'b1;
          else                    state   <= S_SETUP;
        end
        S_SETUP: if (!(wr_q && hz != '0)) begin
          cnt   <= '0;
          state <= wr_q ? S_WR : S_RD;
        end
        S_RD: if (cnt == CW'(C_RD - 1)) begin
          rsp_rdata <= rd_masked;
          req_ack   <= 1'b1;
          hz        <= HW'(C_HZ);
          state     <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        S_WR: if (cnt == CW'(C_WA - 1)) begin
          cnt   <= '0;
          state <= S_REC;
        end else cnt <= cnt + 1'b1;
        S_REC: if (cnt == CW'(C_REC - 1)) begin
          req_ack <= 1'b1;
          state   <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  logic [7:0] we_run, oe_off;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_run <= '0;
      oe_off <= 8'hFF;
    end else begin
      we_run <= !mem_we_n ? ((we_run == 8'hFF) ? we_run : we_run + 1'b1) : 8'h00;
      oe_off <= mem_oe_n  ? ((oe_off == 8'hFF) ? oe_off : oe_off + 1'b1) : 8'h00;
    end
  end

  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && $past(!rst_n ? 1'b1 : 1'b1)) |-> $stable(mem_addr))
    else $error("a_r2_addr_hold");

  a_r4_we_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run >= 8'(C_WA)))
    else $error("a_r4_we_width");

  a_r8_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_dq_oe) |-> (oe_off >= 8'(C_HZ)))
    else $error("a_r8_turnaround");

  a_r9_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n)
    else $error("a_r9_strobe_excl");

  a_r9_no_drive_under_oe: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n)
    else $error("a_r9_no_drive_under_oe");

  a_r10_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack)
    else $error("a_r10_ack_single");

  a_r7_no_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && req_valid && !req_ack && req_lanes == 2'b00) |=> (req_ack && mem_cs_n))
    else $error("a_r7_no_lane");

endmodule

// File: tb/psram_host_ctrl_tb_top.sv
`timescale 1ns/1ps
module psram_host_ctrl_tb_top;

  function automatic int ns2cyc(input int ns);
    int c;
    c = (ns + 9) / 10;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int B_RD  = imax(ns2cyc(55), imax(ns2cyc(55), ns2cyc(55)));
  localparam int B_WA  = imax(imax(ns2cyc(40), ns2cyc(45)), imax(ns2cyc(45), imax(ns2cyc(50), ns2cyc(25))));
  localparam int B_WC  = ns2cyc(55);
  localparam int B_REC = (B_WC > B_WA) ? (B_WC - B_WA) : 1;
  localparam int B_HZ  = ns2cyc(25);

  logic        clk = 0, rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_lanes = '0;
  logic        req_ack;
  logic [15:0] rsp_rdata;
  logic [17:0] mem_addr;
  logic        mem_cs_n, mem_cs, mem_we_n, mem_oe_n, mem_ub_n, mem_lb_n, mem_dq_oe;
  logic [15:0] mem_dq_o, mem_dq_i;

  always #5 clk = ~clk;

  psram_host_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_lanes(req_lanes),
    .req_ack(req_ack), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_cs_n(mem_cs_n), .mem_cs(mem_cs), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n), .mem_dq_o(mem_dq_o),
    .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  function automatic logic [15:0] init_word(input int i);
    return 16'(i * 37) ^ 16'hC35A;
  endfunction

  // memory model
  logic [15:0] mem [0:1023];
  int          oe_run = 0;
  logic        pend = 0, p_lb = 0, p_ub = 0;
  logic [9:0]  p_idx = '0;
  logic [15:0] p_dat = '0;
  initial for (int i = 0; i < 1024; i++) mem[i] = init_word(i);

  wire sel   = !mem_cs_n && mem_cs;
  wire rd_on = sel && !mem_oe_n && mem_we_n;
  wire wr_on = sel && !mem_we_n && !(mem_ub_n && mem_lb_n);

  always @(posedge clk) begin
    oe_run <= rd_on ? oe_run + 1 : 0;
    if (wr_on) begin
      pend <= 1; p_idx <= mem_addr[9:0]; p_dat <= mem_dq_o;
      p_lb <= !mem_lb_n; p_ub <= !mem_ub_n;
    end else if (pend) begin
      pend <= 0;
      if (p_lb) mem[p_idx][7:0]  <= p_dat[7:0];
      if (p_ub) mem[p_idx][15:8] <= p_dat[15:8];
    end
  end

  always_comb begin
    if (rd_on && oe_run >= 2) begin
      mem_dq_i[7:0]  = !mem_lb_n ? mem[mem_addr[9:0]][7:0]  : 8'h5A;
      mem_dq_i[15:8] = !mem_ub_n ? mem[mem_addr[9:0]][15:8] : 8'h5A;
    end else mem_dq_i = 16'hEEEE;
  end

  // negedge monitor
  bit ce_prev = 0, we_prev = 0, dqoe_prev = 0, ack_prev = 0, ce_seen = 0;
  int ce_len = 0, last_ce_len = 0, we_len = 0, last_we_len = 0;
  int oe_hi = 1000, last_gap = 1000, ack_count = 0;
  int setup_bad = 0, hold_bad = 0, excl_bad = 0, sd_bad = 0, ack_bad = 0;
  logic [17:0] addr_prev = '0, first_addr = '0;

  always @(negedge clk) if (rst_n) begin
    if (sel) begin
      ce_seen = 1;
      if (!ce_prev) begin
        ce_len = 0; first_addr = mem_addr;
        if (mem_addr != addr_prev) setup_bad++;
      end else if (mem_addr != addr_prev) hold_bad++;
      ce_len++;
    end else if (ce_prev) begin
      last_ce_len = ce_len;
      if (mem_addr != addr_prev) hold_bad++;
    end
    if (!mem_we_n) begin
      if (!we_prev) we_len = 0;
      we_len++;
      if (!mem_dq_oe) sd_bad++;
    end else if (we_prev) last_we_len = we_len;
    if (!mem_we_n && !mem_oe_n) excl_bad++;
    if (mem_dq_oe && !mem_oe_n) excl_bad++;
    if (mem_dq_oe && !dqoe_prev) last_gap = oe_hi;
    if (mem_oe_n) begin if (oe_hi < 1000) oe_hi++; end else oe_hi = 0;
    if (req_ack && ack_prev) ack_bad++;
    if (req_ack) ack_count++;
    ce_prev = sel; we_prev = !mem_we_n; dqoe_prev = mem_dq_oe;
    ack_prev = req_ack; addr_prev = mem_addr;
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic chk_ge(input string rq, input int act, input int lim);
    checks++;
    if (act < lim) begin
      errors++;
      $display("FAIL %s actual %0d expected >= %0d", rq, act, lim);
    end
  endtask

  task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d,
                        input logic [1:0] ln, input bit idle_first,
                        output logic [15:0] rd, output int lat);
    if (idle_first) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_lanes = ln;
    lat = 0;
    do begin @(negedge clk); lat++; end while (!req_ack && lat < 200);
    rd = rsp_rdata;
    req_valid = 0;
    #1;
  endtask

  int acc_count = 0;

  task automatic t_reset;
    chk("R1 cs_n", mem_cs_n, 1); chk("R1 cs", mem_cs, 0);
    chk("R1 we_n", mem_we_n, 1); chk("R1 oe_n", mem_oe_n, 1);
    chk("R1 ub_n/lb_n", {mem_ub_n, mem_lb_n}, 2'b11);
    chk("R1 dq_oe", mem_dq_oe, 0); chk("R1 ack", req_ack, 0);
  endtask

  task automatic t_write_read;
    logic [15:0] rd; int lat;
    access(1, 18'h000A5, 16'h1234, 2'b11, 1, rd, lat); acc_count++;
    chk("R5 write latency", lat, 2 + B_WA + B_REC);
    chk("R4 we low cycles", last_we_len, B_WA);
    chk("R4 cs active cycles on write", last_ce_len, B_WA);
    access(0, 18'h000A5, 16'h0, 2'b11, 1, rd, lat); acc_count++;
    chk("R3 read latency", lat, 2 + B_RD);
    chk("R3 cs active cycles on read", last_ce_len, B_RD);
    chk("R3 read data", rd, 16'h1234);
  endtask

  task automatic t_lanes;
    logic [15:0] rd; int lat;
    logic [15:0] orig = init_word(10'h055);
    access(1, 18'h00055, 16'hBEEF, 2'b01, 1, rd, lat); acc_count++;
    access(0, 18'h00055, 16'h0, 2'b11, 1, rd, lat); acc_count++;
    chk("R6 low lane write only", rd, {orig[15:8], 8'hEF});
    access(1, 18'h00055, 16'h1234, 2'b10, 1, rd, lat); acc_count++;
    access(0, 18'h00055, 16'h0, 2'b10, 1, rd, lat); acc_count++;
    chk("R3 upper lane read, lower zero", rd, 16'h1200);
    access(0, 18'h00055, 16'h0, 2'b01, 1, rd, lat); acc_count++;
    chk("R3 lower lane read, upper zero", rd, 16'h00EF);
  endtask

  task automatic t_no_lane;
    logic [15:0] rd; int lat;
    @(negedge clk); #1; ce_seen = 0;
    access(1, 18'h00077, 16'hFFFF, 2'b00, 0, rd, lat); acc_count++;
    chk("R7 no-lane ack latency", lat, 1);
    chk("R7 no chip select", ce_seen, 0);
    access(0, 18'h00077, 16'h0, 2'b11, 1, rd, lat); acc_count++;
    chk("R7 word unchanged", rd, init_word(10'h077));
  endtask

  task automatic t_addr;
    logic [15:0] rd; int lat;
    access(1, 18'h2A5C3, 16'h5AA5, 2'b11, 1, rd, lat); acc_count++;
    chk("R2 full address driven", first_addr, 18'h2A5C3);
    access(0, 18'h2A5C3, 16'h0, 2'b11, 1, rd, lat); acc_count++;
    chk("R2 readback at high address", rd, 16'h5AA5);
  endtask

  task automatic t_turnaround;
    logic [15:0] rd; int lat;
    access(0, 18'h00010, 16'h0, 2'b11, 1, rd, lat); acc_count++;
    chk("R3 read before turnaround", rd, init_word(10'h010));
    access(1, 18'h00011, 16'hC0DE, 2'b11, 0, rd, lat); acc_count++;
    chk_ge("R8 oe high cycles before drive", last_gap, B_HZ);
    access(1, 18'h00012, 16'hF00D, 2'b11, 0, rd, lat); acc_count++;
    access(0, 18'h00011, 16'h0, 2'b11, 1, rd, lat); acc_count++;
    chk("R8 write after read stored", rd, 16'hC0DE);
    access(0, 18'h00012, 16'h0, 2'b11, 0, rd, lat); acc_count++;
    chk("R10 back-to-back write stored", rd, 16'hF00D);
  endtask

  task automatic t_protocol;
    chk("R2 address setup violations", setup_bad, 0);
    chk("R2 address hold violations", hold_bad, 0);
    chk("R4 data not driven during write", sd_bad, 0);
    chk("R9 strobe/driver conflicts", excl_bad, 0);
    chk("R10 multi-cycle acks", ack_bad, 0);
    chk("R10 ack count", ack_count, acc_count);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_write_read;
    t_lanes;
    t_no_lane;
    t_addr;
    t_turnaround;
    repeat (2) @(negedge clk);
    t_protocol;
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule